// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets a processor reach the registers of an attached Ethernet PHY through the two-wire serial management bus. Software writes one 32-bit command word that holds the PHY address, the register address, the direction and, for a write, the data. The word starts a complete clause-22 frame on its own. The engine then generates the management clock, shifts the frame out and, for a read, releases the data line and collects the PHY's answer into the low half of the same word.

While a frame is on the wire the command word reports busy, and any new command is dropped. When the frame ends, a one-cycle completion interrupt fires. After a read, a valid flag is set and the returned data sits in the data field.

A small watcher follows every completed read of PHY register 1, the basic status register. The first such read records a baseline. After that, a read whose value differs from the stored one raises a status-change interrupt at the same time as the completion interrupt.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The command word reads back as bit 28 busy, bit 27 read-valid, bit 26 direction (1 read, 0 write), bits 25:21 register address, bits 20:16 PHY address and bits 15:0 data. Bits 31:29 always read as zero, whatever was written to them.
- R2: An accepted command sets busy in the next cycle. Busy stays set until the last bit period of the frame has ended and then clears.
- R3: Each frame consists of 32 preamble ones, start `01`, an opcode (`10` for read, `01` for write), the PHY address and then the register address, both MSB first. A write follows these with turnaround `10` and 16 data bits MSB first. The data line changes only on falling MDC edges and is driven for the whole of a write frame.
- R4: During a read the output enable is low for the 2 turnaround bits and the 16 data bits. `mdio_i` is sampled at each of the 16 data-bit MDC rising edges, MSB first, into bits 15:0. Read-valid (bit 27) is set when the frame completes.
- R5: MDC has a period of `CLK_DIV` system clocks with equal high and low halves. It is low whenever the engine is idle.
- R6: `done_irq` pulses for exactly one cycle per completed frame, in the first cycle in which busy reads zero.
- R7: A command written while busy is set is ignored: neither the word nor the frame on the wire changes.
- R8: Read-valid reads zero in the cycle after any new command is accepted.
- R9: A completed read of PHY register 1 raises `phy_chg_irq` together with `done_irq` only if a baseline exists and the new value differs from it. The first read of register 1 sets the baseline silently. Writes and reads of other registers leave the baseline and the interrupt unchanged.
- R10: After reset the command word is zero, MDC is low, the output enable is low and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word write value |
| cmd_word | output | 32 | Command word read-back with flags |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the PHY |
| mdio_o | output | 1 | Management data driven to the PHY |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| done_irq | output | 1 | One-cycle completion pulse |
| phy_chg_irq | output | 1 | One-cycle PHY status change pulse |

## Verification
A wrong bit index in the sequencer shows up on the wire within one MDC period. The captured frame then has a bit or an output-enable phase shifted, or the read data lands rotated in bits 15:0. A busy flag stuck high or low shows at the next command: the interrupt comes too early or never, or a command written mid-frame changes the fields that are read back. A corrupted baseline in the status watcher shows at the next read of register 1 as a missing or spurious change pulse.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int POS_BUSY = 28;
  localparam int POS_VALID = 27;

  // bits 26:0 of the command word, in hardware order
  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] reg_a;
    logic [ADDR_W-1:0] phy_a;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
endpackage

// File: rtl/mdc_gen.sv
`timescale 1ns/1ps
module mdc_gen #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));
  assign rise = run && wrap && !mdc;
  assign fall = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: mdc only moves at a half-period boundary
  assert_mdc_edges_R5: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(wrap)) |-> $stable(mdc));
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_i,
  output logic              active,
  output logic              fin,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rx_data
);
  localparam int FRAME    = PRE_LEN + 32;
  localparam int TA_POS   = PRE_LEN + 14;
  localparam int DATA_POS = PRE_LEN + 16;
  localparam int LAST     = FRAME - 1;
  localparam int IW       = $clog2(FRAME);

  logic [FRAME-1:0] sh;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    nxt;
  logic             rd;

  assign nxt    = idx + 1'b1;
  assign fin    = active && mdc_fall && (idx == IW'(LAST));
  assign mdio_o = sh[FRAME-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      idx     <= '0;
      rd      <= 1'b0;
      active  <= 1'b0;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (start && !active) begin
      sh      <= {{PRE_LEN{1'b1}}, SOF_CODE, cmd.rd ? OP_RD : OP_WR,
                  cmd.phy_a, cmd.reg_a, TA_WR,
                  cmd.rd ? {DATA_W{1'b1}} : cmd.data};
      idx     <= '0;
      rd      <= cmd.rd;
      active  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (mdc_rise && rd && idx >= IW'(DATA_POS))
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
      if (mdc_fall) begin
        if (idx == IW'(LAST)) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
          sh      <= '1;
        end else begin
          idx     <= nxt;
          sh      <= {sh[FRAME-2:0], 1'b1};
          mdio_oe <= !(rd && nxt >= IW'(TA_POS));
        end
      end
    end
  end

  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    (active && rd && idx >= IW'(TA_POS)) |-> !mdio_oe);
  assert_write_drive_R3: assert property (@(posedge clk) disable iff (rst)
    (active && !rd) |-> mdio_oe);
  assert_stable_rise_R3: assert property (@(posedge clk) disable iff (rst)
    mdc_rise |=> $stable(mdio_o));
endmodule

// File: rtl/phy_stat_watch.sv
`timescale 1ns/1ps
module phy_stat_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] val,
  output logic         chg
);
  logic         seen;
  logic [W-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      last <= '0;
      chg  <= 1'b0;
    end else begin
      chg <= upd && seen && (val != last);
      if (upd) begin
        last <= val;
        seen <= 1'b1;
      end
    end
  end

  // R9: no change reported before a baseline exists
  assert_needs_base_R9: assert property (@(posedge clk) disable iff (rst)
    chg |-> $past(seen));
endmodule

// File: rtl/mdio_cmd_engine.sv
`timescale 1ns/1ps
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int CLK_DIV   = 20,
  parameter int PRE_LEN   = 32,
  parameter int WATCH_REG = 1,
  parameter bit WATCH_EN  = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] cmd_word,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done_irq,
  output logic        phy_chg_irq
);
  mdio_cmd_t         cmd_in;
  mdio_cmd_t         cur;
  logic              valid_r;
  logic              busy;
  logic              fin;
  logic              accept;
  logic              rise;
  logic              fall;
  logic [DATA_W-1:0] rx_data;
  logic              watch_upd;
  logic [4:0]        unused_hi;

  assign cmd_in    = mdio_cmd_t'(wr_data[26:0]);
  assign unused_hi = wr_data[31:27];
  assign accept    = wr_en && !busy;
  assign watch_upd = fin && cur.rd && (cur.reg_a == ADDR_W'(WATCH_REG));
  assign cmd_word  = {3'b000, busy, valid_r, cur};

  mdc_gen #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .mdc(mdc), .rise(rise), .fall(fall));

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .cmd(cmd_in),
    .mdc_rise(rise), .mdc_fall(fall), .mdio_i(mdio_i),
    .active(busy), .fin(fin), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rx_data(rx_data));

  generate
    if (WATCH_EN) begin : g_watch
      phy_stat_watch #(.W(DATA_W)) u_watch (
        .clk(clk), .rst(rst), .upd(watch_upd), .val(rx_data), .chg(phy_chg_irq));
    end else begin : g_nowatch
      assign phy_chg_irq = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur      <= '0;
      valid_r  <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= fin;
      if (accept) begin
        cur     <= cmd_in;
        valid_r <= 1'b0;
      end else if (fin && cur.rd) begin
        cur.data <= rx_data;
        valid_r  <= 1'b1;
      end
    end
  end

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !busy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  assert_fields_hold_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({cur.rd, cur.reg_a, cur.phy_a}));
  assert_valid_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !valid_r);
  assert_chg_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    phy_chg_irq |-> done_irq);
endmodule

// File: tb/mdio_cmd_engine_test.sv
`timescale 1ns/1ps
module mdio_cmd_engine_test;
  localparam int DIV = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_word;
  logic        mdc, mdio_i, mdio_o, mdio_oe, done_irq, phy_chg_irq;

  int total = 0;
  int bad = 0;
  logic        have_prev = 1'b0;
  logic [15:0] prev_val = '0;

  always #10 clk = ~clk;

  mdio_cmd_engine #(.CLK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cmd_word(cmd_word),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_irq(done_irq), .phy_chg_irq(phy_chg_irq));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
      input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, 2'b10, d};
  endfunction

  function automatic logic [63:0] exp_oe(input bit rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
      input logic [15:0] d, input logic [15:0] resp, input bit poke);
    logic [63:0] cap_v, cap_oe, ef, eo;
    logic [31:0] exp_w;
    bit busy_ok, exp_chg;
    int n_done, n_chg;
    time t0, t1;
    logic [2:0] hi;
    hi = 3'($urandom);
    cap_v = '0; cap_oe = '0; busy_ok = 1'b1;
    mdio_i = 1'b1;
    write_cmd({hi, 1'b0, 1'b0, rd, ra, phy, d});
    chk(cmd_word[28] == 1'b1, "R2 busy after launch", 64'(cmd_word[28]), 64'd1);
    chk(cmd_word[27] == 1'b0, "R8 valid cleared on accept", 64'(cmd_word[27]), 64'd0);
    t0 = 0; t1 = 0;
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      if (k == 0) t0 = $time;
      if (k == 1) t1 = $time;
      cap_v[63-k] = mdio_o;
      cap_oe[63-k] = mdio_oe;
      if (cmd_word[28] !== 1'b1) busy_ok = 1'b0;
      mdio_i = ((k + 1) >= 48 && (k + 1) <= 63) ? resp[63-(k+1)] : 1'b1;
      if (poke && k == 10) write_cmd(32'h0FFF_A5A5 ^ {5'b0, rd, 26'b0});
    end
    chk(busy_ok, "R2 busy held during frame", 64'(busy_ok), 64'd1);
    chk((t1 - t0) == time'(DIV * 20), "R5 mdc period", 64'(t1 - t0), 64'(DIV * 20));
    ef = exp_frame(rd, phy, ra, d);
    eo = exp_oe(rd);
    chk(cap_oe == eo, rd ? "R4 output enable phases" : "R3 output enable phases",
        cap_oe, eo);
    chk((cap_v & eo) == (ef & eo), poke ? "R7 frame unchanged by busy write" :
        "R3 frame bits", cap_v & eo, ef & eo);
    n_done = 0; n_chg = 0;
    repeat (DIV) begin
      @(negedge clk);
      if (done_irq) begin
        n_done++;
        chk(cmd_word[28] == 1'b0, "R6 done with busy low", 64'(cmd_word[28]), 64'd0);
      end
      if (phy_chg_irq) n_chg++;
    end
    chk(n_done == 1, "R6 single done pulse", 64'(n_done), 64'd1);
    exp_chg = 1'b0;
    if (rd && ra == 5'd1) begin
      exp_chg = have_prev && (resp != prev_val);
      have_prev = 1'b1;
      prev_val = resp;
    end
    chk(n_chg == int'(exp_chg), "R9 status change pulse", 64'(n_chg), 64'(exp_chg));
    exp_w = {3'b000, 1'b0, rd, rd, ra, phy, rd ? resp : d};
    chk(cmd_word == exp_w, poke ? "R7 word unchanged by busy write" :
        (rd ? "R4 read data and valid" : "R1 word readback"), 64'(cmd_word), 64'(exp_w));
    @(negedge mdc or negedge clk);
    chk(mdc == 1'b0, "R5 mdc low when idle", 64'(mdc), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(cmd_word == 32'h0 && !mdc && !mdio_oe && !done_irq && !phy_chg_irq,
        "R10 reset state", {cmd_word, 27'b0, mdc, mdio_oe, done_irq, phy_chg_irq, 1'b0},
        64'h0);
    // directed status watch sequence
    run_txn(1'b1, 5'd3, 5'd1, 16'h0, 16'h796D, 1'b0);   // baseline
    run_txn(1'b1, 5'd3, 5'd1, 16'h0, 16'h796D, 1'b0);   // same value
    run_txn(1'b1, 5'd3, 5'd1, 16'h0, 16'h7969, 1'b0);   // change
    run_txn(1'b1, 5'd3, 5'd2, 16'h0, 16'h1234, 1'b0);   // other register
    run_txn(1'b0, 5'd3, 5'd1, 16'hBEEF, 16'h0, 1'b0);   // write to reg 1
    run_txn(1'b1, 5'd3, 5'd1, 16'h0, 16'h7969, 1'b0);   // still the baseline
    // writes issued while busy
    run_txn(1'b1, 5'd31, 5'd0, 16'h0, 16'h8001, 1'b1);
    run_txn(1'b0, 5'd0, 5'd31, 16'hFFFF, 16'h0, 1'b1);
    run_txn(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0, 1'b0);
    for (int i = 0; i < 10; i++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom % 3), 16'($urandom),
              16'($urandom), 1'($urandom % 4 == 0));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule